// File: doc/BRIEF.md
# SPI-aware general-purpose I/O port slice

This block is the pad-side control for one eight-pin general-purpose I/O port. For each pin it produces an output enable, an output value and a pull-up enable, and it returns a synchronized copy of the pad levels. Four of the pins can be taken over by a serial peripheral interface unit. Whether the SPI unit forces one of these pins to input depends on the pin's role and on whether the unit is master or slave. If the pin is not forced, its direction comes from the direction register. Two more pins can carry timer compare outputs. Every pin can be a source for one shared pin-change interrupt flag.

The SPI shift logic and the timers live elsewhere. They provide the serial output levels and the compare levels. The block chooses, pin by pin, which source drives the pad. Software-visible registers are supplied as plain inputs.

Top module: `gsp_port`

## Requirements
- R1: With the SPI disabled and both compare enables low, every pin has `pad_oe` equal to its `dir_bits` bit and `pad_out` equal to its `port_bits` bit.
- R2: With the SPI enabled as master (`spi_on`=1, `spi_is_master`=1), pin 3 (serial data in for a master) has `pad_oe`=0 whatever `dir_bits[3]` holds.
- R3: With the SPI enabled as slave (`spi_on`=1, `spi_is_master`=0), pins 0 (select), 1 (serial clock) and 2 (serial data out for a master) have `pad_oe`=0 whatever the direction bits hold.
- R4: In master mode, pins 0, 1 and 2 take `pad_oe` from their direction bits. `pad_out[2]` equals `spi_mosi` and `pad_out[1]` equals `spi_sck`. `pad_out[0]` equals `port_bits[0]`.
- R5: In slave mode, pin 3 takes `pad_oe` from `dir_bits[3]`. `pad_out[3]` equals `spi_miso` only while the synchronized level of pin 0 is low. Otherwise it equals `port_bits[3]`.
- R6: `pad_pu[i]` is 1 exactly when `pad_oe[i]`=0, `port_bits[i]`=1 and `pu_off`=0. This also holds for pins that the SPI override forces to input.
- R7: With `cmp_a_en`=1, pin 5 drives `pad_out[5]`=`cmp_a` and has `pad_oe[5]`=`dir_bits[5]`. Pin 6 does the same with `cmp_b_en` and `cmp_b`. A pin whose compare enable is low behaves as in R1.
- R8: `pin_rd` equals `pad_in` as sampled two rising clock edges earlier.
- R9: `pc_flag` goes high one edge after a synchronized pin whose `pc_mask` bit is 1 changes level. A level change on a pin whose mask bit is 0 leaves the flag low.
- R10: Once set, `pc_flag` stays high until a cycle with `pc_clr`=1. If a new masked change arrives in that same cycle, the flag stays set.
- R11: While `rst` is high, the synchronizer stages, the change-detect history and `pc_flag` all clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_bits | input | 8 | Direction register, 1 = output |
| port_bits | input | 8 | Output value or pull-up request per pin |
| pu_off | input | 1 | Global pull-up disable |
| spi_on | input | 1 | SPI unit enabled |
| spi_is_master | input | 1 | 1 = master, 0 = slave |
| spi_mosi | input | 1 | Master serial data output level |
| spi_sck | input | 1 | Master serial clock output level |
| spi_miso | input | 1 | Slave serial data output level |
| cmp_a | input | 1 | Compare output A level |
| cmp_a_en | input | 1 | Compare output A owns pin 5 |
| cmp_b | input | 1 | Compare output B level |
| cmp_b_en | input | 1 | Compare output B owns pin 6 |
| pc_mask | input | 8 | Pin-change source enable per pin |
| pc_clr | input | 1 | Write-one-to-clear strobe for the flag |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pull-up enable |
| pin_rd | output | 8 | Synchronized pad levels |
| pc_flag | output | 1 | Pin-change interrupt flag |

## Verification
The hardest case to reach is slave-mode data-in-for-master gating. The select level that gates `spi_miso` is not a port of its own. It is the synchronized copy of pad pin 0, so it reaches the mux two edges after the pad moves. The bench drives pad pin 0 high and then low, waits out both synchronizer stages, and only then samples `pad_out[3]`. The set-versus-clear collision is reached in a similar way. A masked pad bit is toggled, the bench counts edges until the change reaches the second stage, and it asserts `pc_clr` in exactly that cycle.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

    typedef enum logic [2:0] {
        ROLE_GPIO,
        ROLE_SEL,
        ROLE_CLK,
        ROLE_MDO,
        ROLE_MDI,
        ROLE_CMPA,
        ROLE_CMPB
    } pin_role_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drv_t;

    typedef struct packed {
        logic on;
        logic master;
        logic slv_act;
        logic mosi;
        logic sck;
        logic miso;
    } spi_ctl_t;

    typedef struct packed {
        logic a;
        logic a_en;
        logic b;
        logic b_en;
    } cmp_ctl_t;

    function automatic pin_role_e role_for(input int idx, input int sel_b, input int clk_b,
                                           input int mdo_b, input int mdi_b,
                                           input int ca_b, input int cb_b);
        if (idx == sel_b) return ROLE_SEL;
        if (idx == clk_b) return ROLE_CLK;
        if (idx == mdo_b) return ROLE_MDO;
        if (idx == mdi_b) return ROLE_MDI;
        if (idx == ca_b)  return ROLE_CMPA;
        if (idx == cb_b)  return ROLE_CMPB;
        return ROLE_GPIO;
    endfunction

    function automatic pin_drv_t resolve(input pin_role_e role, input logic dir_b,
                                         input logic port_b, input spi_ctl_t s,
                                         input cmp_ctl_t c);
        pin_drv_t d;
        logic slave_mode;
        logic master_mode;
        slave_mode  = s.on && !s.master;
        master_mode = s.on && s.master;
        d.oe  = dir_b;
        d.val = port_b;
        unique case (role)
            ROLE_SEL: if (slave_mode) d.oe = 1'b0;
            ROLE_CLK: begin
                if (slave_mode)  d.oe  = 1'b0;
                if (master_mode) d.val = s.sck;
            end
            ROLE_MDO: begin
                if (slave_mode)  d.oe  = 1'b0;
                if (master_mode) d.val = s.mosi;
            end
            ROLE_MDI: begin
                if (master_mode) d.oe = 1'b0;
                if (slave_mode && s.slv_act) d.val = s.miso;
            end
            ROLE_CMPA: if (c.a_en) d.val = c.a;
            ROLE_CMPB: if (c.b_en) d.val = c.b;
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gsp_sync.sv
module gsp_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gsp_pin_mux.sv
module gsp_pin_mux
    import gsp_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int SEL_BIT = 0,
    parameter int CLK_BIT = 1,
    parameter int MDO_BIT = 2,
    parameter int MDI_BIT = 3,
    parameter int CMPA_BIT = 5,
    parameter int CMPB_BIT = 6
) (
    input  logic [WIDTH-1:0] dir_bits,
    input  logic [WIDTH-1:0] port_bits,
    input  logic             pu_off,
    input  spi_ctl_t         spi,
    input  cmp_ctl_t         cmp,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] val,
    output logic [WIDTH-1:0] pu
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        localparam pin_role_e ROLE =
            role_for(i, SEL_BIT, CLK_BIT, MDO_BIT, MDI_BIT, CMPA_BIT, CMPB_BIT);
        pin_drv_t drv;
        always_comb begin
            drv   = resolve(ROLE, dir_bits[i], port_bits[i], spi, cmp);
            oe[i] = drv.oe;
            val[i] = drv.val;
            pu[i] = !drv.oe && port_bits[i] && !pu_off;
        end
    end
endmodule

// File: rtl/gsp_pc_detect.sv
module gsp_pc_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] mask,
    input  logic             clr,
    output logic             flag
);
    logic [WIDTH-1:0] hist;
    logic             hit;

    assign hit = |((lvl ^ hist) & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
            flag <= 1'b0;
        end else begin
            hist <= lvl;
            if (hit)      flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/gsp_port.sv
module gsp_port
    import gsp_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_BIT = 0,
    parameter int CLK_BIT = 1,
    parameter int MDO_BIT = 2,
    parameter int MDI_BIT = 3,
    parameter int CMPA_BIT = 5,
    parameter int CMPB_BIT = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] dir_bits,
    input  logic [WIDTH-1:0] port_bits,
    input  logic             pu_off,
    input  logic             spi_on,
    input  logic             spi_is_master,
    input  logic             spi_mosi,
    input  logic             spi_sck,
    input  logic             spi_miso,
    input  logic             cmp_a,
    input  logic             cmp_a_en,
    input  logic             cmp_b,
    input  logic             cmp_b_en,
    input  logic [WIDTH-1:0] pc_mask,
    input  logic             pc_clr,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu,
    output logic [WIDTH-1:0] pin_rd,
    output logic             pc_flag
);
    spi_ctl_t spi;
    cmp_ctl_t cmp;

    gsp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(pin_rd)
    );

    always_comb begin
        spi.on      = spi_on;
        spi.master  = spi_is_master;
        spi.slv_act = !pin_rd[SEL_BIT];
        spi.mosi    = spi_mosi;
        spi.sck     = spi_sck;
        spi.miso    = spi_miso;
        cmp.a       = cmp_a;
        cmp.a_en    = cmp_a_en;
        cmp.b       = cmp_b;
        cmp.b_en    = cmp_b_en;
    end

    gsp_pin_mux #(
        .WIDTH(WIDTH), .SEL_BIT(SEL_BIT), .CLK_BIT(CLK_BIT), .MDO_BIT(MDO_BIT),
        .MDI_BIT(MDI_BIT), .CMPA_BIT(CMPA_BIT), .CMPB_BIT(CMPB_BIT)
    ) u_mux (
        .dir_bits(dir_bits), .port_bits(port_bits), .pu_off(pu_off),
        .spi(spi), .cmp(cmp), .oe(pad_oe), .val(pad_out), .pu(pad_pu)
    );

    gsp_pc_detect #(.WIDTH(WIDTH)) u_pc (
        .clk(clk), .rst(rst), .lvl(pin_rd), .mask(pc_mask), .clr(pc_clr), .flag(pc_flag)
    );
endmodule

// File: rtl/gsp_port_chk.sv
module gsp_port_chk #(
    parameter int WIDTH = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_BIT = 0,
    parameter int CLK_BIT = 1,
    parameter int MDO_BIT = 2,
    parameter int MDI_BIT = 3,
    parameter int CMPA_BIT = 5,
    parameter int CMPB_BIT = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] dir_bits,
    input logic [WIDTH-1:0] port_bits,
    input logic             pu_off,
    input logic             spi_on,
    input logic             spi_is_master,
    input logic             pc_clr,
    input logic [WIDTH-1:0] pad_in,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_pu,
    input logic [WIDTH-1:0] pin_rd,
    input logic             pc_flag
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    a_r2_mdi_forced_in: assert property (@(posedge clk) disable iff (rst)
        (spi_on && spi_is_master) |-> !pad_oe[MDI_BIT]);

    a_r3_slave_forced_in: assert property (@(posedge clk) disable iff (rst)
        (spi_on && !spi_is_master) |->
            (!pad_oe[SEL_BIT] && !pad_oe[CLK_BIT] && !pad_oe[MDO_BIT]));

    a_r6_pu_never_driving: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_oe) == '0);

    a_r6_pu_blocked: assert property (@(posedge clk) disable iff (rst)
        pu_off |-> pad_pu == '0);

    a_r8_two_stage: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> pin_rd == $past(pad_in, 2));

    a_r10_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (pc_flag && !pc_clr) |=> pc_flag);

    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (!pc_flag && pin_rd == '0));

    logic unused_ok;
    assign unused_ok = ^{dir_bits, port_bits};
endmodule

bind gsp_port gsp_port_chk #(
    .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .SEL_BIT(SEL_BIT), .CLK_BIT(CLK_BIT),
    .MDO_BIT(MDO_BIT), .MDI_BIT(MDI_BIT), .CMPA_BIT(CMPA_BIT), .CMPB_BIT(CMPB_BIT)
) u_chk (.*);

// File: tb/test_gsp_port.sv
module test_gsp_port;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] dir_bits, port_bits, pc_mask, pad_in;
    logic       pu_off, spi_on, spi_is_master, spi_mosi, spi_sck, spi_miso;
    logic       cmp_a, cmp_a_en, cmp_b, cmp_b_en, pc_clr;
    logic [7:0] pad_oe, pad_out, pad_pu, pin_rd;
    logic       pc_flag;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    gsp_port i_gsp_port (
        .clk(clk), .rst(rst), .dir_bits(dir_bits), .port_bits(port_bits), .pu_off(pu_off),
        .spi_on(spi_on), .spi_is_master(spi_is_master), .spi_mosi(spi_mosi),
        .spi_sck(spi_sck), .spi_miso(spi_miso), .cmp_a(cmp_a), .cmp_a_en(cmp_a_en),
        .cmp_b(cmp_b), .cmp_b_en(cmp_b_en), .pc_mask(pc_mask), .pc_clr(pc_clr),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .pin_rd(pin_rd), .pc_flag(pc_flag)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        pad_in = 8'hFF;
        edges(3);
        chk("R11 pin_rd in reset", pin_rd, 8'h00);
        chk("R11 flag in reset", {7'd0, pc_flag}, 8'h00);
        rst = 1'b0;
        pad_in = 8'h00;
        edges(4);
    endtask

    task automatic t_gpio;
        spi_on = 0; cmp_a_en = 0; cmp_b_en = 0;
        dir_bits = 8'hA5; port_bits = 8'h3C; pu_off = 0;
        #1;
        chk("R1 oe", pad_oe, 8'hA5);
        chk("R1 out", pad_out, 8'h3C);
        chk("R6 pu gpio", pad_pu, 8'h18);
        pu_off = 1; #1;
        chk("R6 pu global off", pad_pu, 8'h00);
        pu_off = 0;
    endtask

    task automatic t_master;
        spi_on = 1; spi_is_master = 1;
        dir_bits = 8'hFF; port_bits = 8'h08; spi_mosi = 1; spi_sck = 0;
        #1;
        chk("R2 master mdi input", pad_oe, 8'hF7);
        chk("R4 master out bits 2..0", pad_out & 8'h07, 8'h04);
        chk("R6 pu forced input", pad_pu, 8'h08);
        spi_mosi = 0; spi_sck = 1; port_bits = 8'h09; #1;
        chk("R4 master out follow spi", pad_out & 8'h07, 8'h03);
        dir_bits = 8'h00; #1;
        chk("R4 master dir follows reg", pad_oe, 8'h00);
    endtask

    task automatic t_slave;
        spi_on = 1; spi_is_master = 0;
        dir_bits = 8'hFF; port_bits = 8'h07; spi_miso = 1;
        pad_in = 8'h01;
        edges(2);
        chk("R3 slave forced inputs", pad_oe, 8'hF8);
        chk("R6 pu on forced inputs", pad_pu, 8'h07);
        chk("R5 mdi idle uses port", {7'd0, pad_out[3]}, 8'h00);
        pad_in = 8'h00;
        @(posedge clk); @(negedge clk);
        chk("R5 one edge after select low", {7'd0, pad_out[3]}, 8'h00);
        edges(1);
        chk("R5 mdi driven from spi", {7'd0, pad_out[3]}, 8'h01);
        dir_bits = 8'hF7; #1;
        chk("R5 mdi dir follows reg", {7'd0, pad_oe[3]}, 8'h00);
        spi_on = 0;
    endtask

    task automatic t_cmp;
        dir_bits = 8'h60; port_bits = 8'h00;
        cmp_a_en = 1; cmp_a = 1; cmp_b_en = 0; cmp_b = 1;
        #1;
        chk("R7 cmp a drives", pad_out & 8'h60, 8'h20);
        chk("R7 cmp oe", pad_oe & 8'h60, 8'h60);
        cmp_a = 0; cmp_b_en = 1; #1;
        chk("R7 cmp levels", pad_out & 8'h60, 8'h40);
        dir_bits = 8'h00; #1;
        chk("R7 cmp needs dir", pad_oe, 8'h00);
        cmp_a_en = 0; cmp_b_en = 0; port_bits = 8'h60; #1;
        chk("R7 disabled back to gpio", pad_out & 8'h60, 8'h60);
    endtask

    task automatic t_sync;
        pad_in = 8'h5A;
        @(posedge clk); @(negedge clk);
        chk("R8 one edge still old", pin_rd, 8'h00);
        edges(1);
        chk("R8 two edges", pin_rd, 8'h5A);
        pad_in = 8'hC3;
        edges(2);
        chk("R8 second pattern", pin_rd, 8'hC3);
    endtask

    task automatic t_pc;
        pc_mask = 8'h0F;
        edges(3);
        pc_clr = 1; edges(1); pc_clr = 0;
        chk("R10 cleared", {7'd0, pc_flag}, 8'h00);
        pad_in = pad_in ^ 8'h80;
        edges(4);
        chk("R9 unmasked change ignored", {7'd0, pc_flag}, 8'h00);
        pad_in = pad_in ^ 8'h02;
        edges(2);
        chk("R9 not yet set", {7'd0, pc_flag}, 8'h00);
        edges(1);
        chk("R9 set after masked change", {7'd0, pc_flag}, 8'h01);
        edges(5);
        chk("R10 holds", {7'd0, pc_flag}, 8'h01);
        pc_clr = 1; edges(1); pc_clr = 0;
        chk("R10 clear works", {7'd0, pc_flag}, 8'h00);
        pad_in = pad_in ^ 8'h04;
        edges(2);
        pc_clr = 1; edges(1); pc_clr = 0;
        chk("R10 set wins over clear", {7'd0, pc_flag}, 8'h01);
        pc_clr = 1; edges(1); pc_clr = 0;
        chk("R10 final clear", {7'd0, pc_flag}, 8'h00);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        dir_bits = 0; port_bits = 0; pc_mask = 0; pad_in = 0; pu_off = 0;
        spi_on = 0; spi_is_master = 0; spi_mosi = 0; spi_sck = 0; spi_miso = 0;
        cmp_a = 0; cmp_a_en = 0; cmp_b = 0; cmp_b_en = 0; pc_clr = 0; rst = 1;
        @(negedge clk);
        t_reset;
        t_gpio;
        t_master;
        t_slave;
        t_cmp;
        t_sync;
        t_pc;
        finish_run;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run;
    end
endmodule